// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block turns a programmed rectangle in memory into a stream of burst requests. Software loads a start address, a row length, a row count and a row pitch. The block then walks the region row by row. Each row is cut into bursts that never exceed the burst beat limit and never run across an address boundary. After each row, the row start jumps by the pitch and not by the row length, so the bytes between rows are skipped. The downstream bus engine consumes the requests and turns them into bus transactions.

Lengths arrive in minus-one form. An optional repeat mode reloads the region from its start address after every pass, with no help from software. A channel side that faces a streaming peripheral carries no address: that build of the block drops the address and the pitch and only splits rows into bursts.

Request flow uses valid/ready. Once `req_valid` is high it stays high, and every request field stays unchanged, until the cycle in which `req_ready` is also high. Only that cycle counts as an accepted request. The consumer may hold `req_ready` low for as long as it likes. The block never withdraws a request it has presented.

Top module: `dma2d_addr_gen`

## Requirements
- R1: The row length in bytes is `cfg_xlen_m1`+1 and the row count is `cfg_ylen_m1`+1. Each row carries floor(`cfg_xlen_m1`/BUS_BYTES)+1 beats.
- R2: The first request of row k starts at start + k·pitch, where k counts from 0. Requests inside a row continue linearly from the row start.
- R3: When `cfg_ylen_m1` is 0, exactly one row is issued and the pitch has no effect.
- R4: Address and pitch bits below log2(BUS_BYTES) are treated as zero.
- R5: Every request carries 1 to MAX_BURST beats. On a memory side, no request crosses a BOUND_BYTES-aligned boundary.
- R6: `req_row_last` marks the final request of each row. `req_xfer_last` marks the final request of the region and is only ever set together with `req_row_last`.
- R7: `done` is high for exactly the one cycle after the request flagged `req_xfer_last` is accepted.
- R8: In repeat mode (`cfg_cyclic`=1), the request after the final one restarts at the start address. `done` pulses at the end of every pass.
- R9: While `enable` is low, the next accepted request ends generation and repeat mode stops. `req_valid` then stays low until a new load.
- R10: A presented request holds `req_valid` and all its fields stable until it is accepted.
- R11: A `cfg_load` pulse is taken only when the block is idle and `enable` is high. Any other load is ignored.
- R12: A streaming-side build (MEM_SIDE=0) drives `req_addr` to zero and splits rows only at MAX_BURST beats.
- R13: After reset, `req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run permission; low ends generation at the next accepted request |
| cfg_load | input | 1 | Single-cycle pulse that loads the parameters and starts a region |
| cfg_addr | input | ADDR_W | Region start address |
| cfg_xlen_m1 | input | XLEN_W | Row length in bytes, minus one |
| cfg_ylen_m1 | input | YLEN_W | Row count, minus one |
| cfg_stride | input | ADDR_W | Distance in bytes between successive row starts |
| cfg_cyclic | input | 1 | Repeat the region until stopped |
| req_valid | output | 1 | A request is presented |
| req_ready | input | 1 | Consumer accepts the presented request |
| req_addr | output | ADDR_W | Burst start address |
| req_beats | output | BURST_W | Beats in this burst (1..MAX_BURST) |
| req_row_last | output | 1 | Final burst of a row |
| req_xfer_last | output | 1 | Final burst of the region |
| done | output | 1 | One-cycle pulse after the final burst is accepted |

## Verification
The bench aims at the following corner cases:
- **Boundary split.** A row that begins 64 bytes before a 4 KB boundary must split there. A design that ignores the boundary would issue one long burst across it. The streaming build, given the same row, must not split there.
- **Pitch.** Rows must advance by the pitch. A design that stepped by the row length would place rows two and three at the wrong addresses.
- **Alignment.** Unaligned addresses, lengths and pitch values check that low bits are dropped rather than rounded up.
- **Back-pressure.** Random stalls check that a request is never changed or dropped while it waits.
- **Repeat mode.** The repeat case checks that each pass restarts at the base and raises `done`.
- **Stop and loads.** Dropping `enable` mid-pass checks the stop rule. Loads issued while busy or disabled must leave the running region unchanged and must not start a new one.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;

  function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/dma2d_row_walker.sv
module dma2d_row_walker #(
  parameter int ADDR_W = 32,
  parameter int YLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] stride_in,
  input  logic [YLEN_W-1:0] rows_m1_in,
  input  logic              advance,
  input  logic              rewind,
  output logic [ADDR_W-1:0] row_addr,
  output logic              last_row
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] stride_q;
  logic [ADDR_W-1:0] row_addr_q;
  logic [YLEN_W-1:0] rows_m1_q;
  logic [YLEN_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      stride_q   <= '0;
      row_addr_q <= '0;
      rows_m1_q  <= '0;
      idx_q      <= '0;
    end else if (load) begin
      base_q     <= base_in;
      stride_q   <= stride_in;
      rows_m1_q  <= rows_m1_in;
      row_addr_q <= base_in;
      idx_q      <= '0;
    end else if (rewind) begin
      row_addr_q <= base_q;
      idx_q      <= '0;
    end else if (advance) begin
      row_addr_q <= row_addr_q + stride_q;
      idx_q      <= idx_q + 1'b1;
    end
  end

  assign row_addr = row_addr_q;
  assign last_row = (idx_q == rows_m1_q);

  // R1: the row index never passes the programmed row count
  a_r1_row_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= rows_m1_q)
    else $error("row index beyond programmed count");

  // R3: a single-row region never moves away from its base
  a_r3_single_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rows_m1_q == '0) |-> (row_addr_q == base_q))
    else $error("single-row region moved by pitch");

endmodule

// File: rtl/dma2d_row_cursor.sv
module dma2d_row_cursor #(
  parameter int BEAT_W  = 22,
  parameter int BURST_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BEAT_W-1:0]  row_beats_in,
  input  logic               clear,
  input  logic               step,
  input  logic [BURST_W-1:0] step_beats,
  output logic [BEAT_W-1:0]  beats_left,
  output logic [BEAT_W-1:0]  beat_ofs
);

  logic [BEAT_W-1:0] row_beats_q;
  logic [BEAT_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_beats_q <= '0;
      ofs_q       <= '0;
    end else begin
      if (load) row_beats_q <= row_beats_in;
      if (load || clear) ofs_q <= '0;
      else if (step)     ofs_q <= ofs_q + BEAT_W'(step_beats);
    end
  end

  assign beats_left = row_beats_q - ofs_q;
  assign beat_ofs   = ofs_q;

  // R6: the offset inside a row never passes the row end
  a_r6_ofs_within_row: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_q <= row_beats_q)
    else $error("row offset past row end");

  // R6: a step never consumes more beats than the row has left
  a_r6_step_fits_row: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (BEAT_W'(step_beats) <= beats_left))
    else $error("burst overruns row");

endmodule

// File: rtl/dma2d_burst_split.sv
module dma2d_burst_split import dma2d_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int BEAT_W      = 22,
  parameter int BURST_W     = 5,
  parameter int OFS_W       = 3,
  parameter int MAX_BURST   = 16,
  parameter int BOUND_BYTES = 4096,
  parameter bit MEM_SIDE    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [BEAT_W-1:0]  beats_left,
  output logic [BURST_W-1:0] burst_beats,
  output logic               fin_row
);

  logic [31:0] room;
  logic [31:0] left32;
  logic [31:0] pick;
  logic        unused_addr;

  assign unused_addr = ^cur_addr;
  assign left32      = 32'(beats_left);

  if (MEM_SIDE) begin : g_bound
    localparam int BND_LSB   = $clog2(BOUND_BYTES);
    localparam int BND_BEATS = BOUND_BYTES >> OFS_W;

    assign room = 32'(BND_BEATS) - 32'(cur_addr[BND_LSB-1:OFS_W]);

    // R5: a burst ends on or before the next boundary
    a_r5_no_boundary_cross: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ((32'(cur_addr[BND_LSB-1:OFS_W]) + 32'(burst_beats)) <= 32'(BND_BEATS)))
      else $error("burst crosses address boundary");
  end else begin : g_flat
    assign room = 32'(MAX_BURST);
  end

  assign pick        = umin(umin(left32, 32'(MAX_BURST)), room);
  assign burst_beats = BURST_W'(pick);
  assign fin_row     = (pick == left32);

  // R5: burst size within 1..MAX_BURST
  a_r5_burst_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (burst_beats != '0 && 32'(burst_beats) <= 32'(MAX_BURST)))
    else $error("burst size out of range");

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen import dma2d_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int XLEN_W      = 24,
  parameter int YLEN_W      = 16,
  parameter int BUS_BYTES   = 8,
  parameter int MAX_BURST   = 16,
  parameter int BOUND_BYTES = 4096,
  parameter bit MEM_SIDE    = 1'b1,
  localparam int BURST_W    = $clog2(MAX_BURST) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cfg_load,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [XLEN_W-1:0]  cfg_xlen_m1,
  input  logic [YLEN_W-1:0]  cfg_ylen_m1,
  input  logic [ADDR_W-1:0]  cfg_stride,
  input  logic               cfg_cyclic,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  output logic               req_row_last,
  output logic               req_xfer_last,
  output logic               done
);

  localparam int OFS_W = $clog2(BUS_BYTES);
  localparam int BEAT_W = XLEN_W - OFS_W + 1;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BUS_BYTES - 1);

  gen_state_e state_q;
  logic cyc_q;
  logic done_q;

  logic [ADDR_W-1:0] base_in;
  logic [ADDR_W-1:0] stride_in;
  logic [BEAT_W-1:0] row_beats_in;
  logic [ADDR_W-1:0] row_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [BEAT_W-1:0] beats_left;
  logic [BEAT_W-1:0] beat_ofs;
  logic [BURST_W-1:0] burst_beats;
  logic last_row;
  logic fin_row;
  logic start;
  logic fire;
  logic row_end;
  logic xfer_end;

  assign start        = cfg_load && enable && (state_q == GEN_IDLE);
  assign req_valid    = (state_q == GEN_RUN);
  assign fire         = req_valid && req_ready;
  assign row_end      = fire && fin_row;
  assign xfer_end     = row_end && last_row;
  assign row_beats_in = BEAT_W'(cfg_xlen_m1 >> OFS_W) + BEAT_W'(1);
  assign cur_addr     = row_addr + ADDR_W'({beat_ofs, {OFS_W{1'b0}}});

  if (MEM_SIDE) begin : g_mem
    assign base_in   = cfg_addr & ~LOW_MASK;
    assign stride_in = cfg_stride & ~LOW_MASK;
    assign req_addr  = cur_addr;
  end else begin : g_stream
    logic unused_side;
    assign unused_side = ^{cfg_addr, cfg_stride, cur_addr};
    assign base_in   = '0;
    assign stride_in = '0;
    assign req_addr  = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GEN_IDLE;
      cyc_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= xfer_end;
      if (start) begin
        state_q <= GEN_RUN;
        cyc_q   <= cfg_cyclic;
      end else if (fire && (!enable || (xfer_end && !cyc_q))) begin
        state_q <= GEN_IDLE;
      end
    end
  end

  dma2d_row_walker #(
    .ADDR_W (ADDR_W),
    .YLEN_W (YLEN_W)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .base_in    (base_in),
    .stride_in  (stride_in),
    .rows_m1_in (cfg_ylen_m1),
    .advance    (row_end && !last_row),
    .rewind     (xfer_end),
    .row_addr   (row_addr),
    .last_row   (last_row)
  );

  dma2d_row_cursor #(
    .BEAT_W  (BEAT_W),
    .BURST_W (BURST_W)
  ) u_cursor (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (start),
    .row_beats_in (row_beats_in),
    .clear        (row_end),
    .step         (fire),
    .step_beats   (burst_beats),
    .beats_left   (beats_left),
    .beat_ofs     (beat_ofs)
  );

  dma2d_burst_split #(
    .ADDR_W      (ADDR_W),
    .BEAT_W      (BEAT_W),
    .BURST_W     (BURST_W),
    .OFS_W       (OFS_W),
    .MAX_BURST   (MAX_BURST),
    .BOUND_BYTES (BOUND_BYTES),
    .MEM_SIDE    (MEM_SIDE)
  ) u_split (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (req_valid),
    .cur_addr    (cur_addr),
    .beats_left  (beats_left),
    .burst_beats (burst_beats),
    .fin_row     (fin_row)
  );

  assign req_beats     = burst_beats;
  assign req_row_last  = fin_row;
  assign req_xfer_last = fin_row && last_row;
  assign done          = done_q;

  // R10: a waiting request is neither withdrawn nor altered
  a_r10_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_beats)
                                   && $stable(req_row_last) && $stable(req_xfer_last)))
    else $error("request changed while stalled");

  // R7: done only follows acceptance of the final request
  a_r7_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready && req_xfer_last))
    else $error("done without final request");

  // R6: end of region is also end of a row
  a_r6_xfer_implies_row: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_xfer_last) |-> req_row_last)
    else $error("region end not on row end");

  // R9: disabled block stops after the accepted request
  a_r9_stop_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !enable) |=> !req_valid)
    else $error("generation continued while disabled");

endmodule

// File: tb/sim_dma2d_addr_gen.sv
module sim_ref #(
  parameter bit MEM  = 1'b1,
  parameter int BUS  = 8,
  parameter int MAXB = 16,
  parameter int BND  = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        load,
  input  logic [31:0] addr,
  input  logic [23:0] x,
  input  logic [15:0] y,
  input  logic [31:0] stride,
  input  logic        cyc,
  input  logic        rdy,
  output logic        e_valid,
  output logic [31:0] e_addr,
  output int          e_beats,
  output logic        e_row_last,
  output logic        e_xfer_last,
  output logic        e_done
);
  bit act = 0;
  bit cy = 0;
  longint base = 0, strd = 0;
  int rows = 1, rbeats = 1, r = 0, o = 0;

  function automatic void calc();
    longint a;
    int left, b;
    a = (base + longint'(r) * strd + longint'(o) * BUS) & 64'hFFFF_FFFF;
    left = rbeats - o;
    b = (left < MAXB) ? left : MAXB;
    if (MEM && ((BND - int'(a % BND)) / BUS) < b) b = (BND - int'(a % BND)) / BUS;
    e_valid     = act;
    e_addr      = MEM ? 32'(a) : 32'd0;
    e_beats     = b;
    e_row_last  = (b == left);
    e_xfer_last = (b == left) && (r == rows - 1);
  endfunction

  initial begin
    e_done = 0;
    calc();
  end

  always @(posedge clk) begin
    bit d;
    d = 0;
    if (!rst_n) begin
      act = 0;
    end else if (act && rdy) begin
      if (e_xfer_last) d = 1;
      if (e_row_last) begin
        o = 0;
        if (r == rows - 1) begin
          r = 0;
          if (!(cy && en)) act = 0;
        end else r = r + 1;
      end else o = o + e_beats;
      if (!en) act = 0;
    end else if (load && en && !act) begin
      act = 1;
      cy = cyc;
      base = MEM ? longint'(addr & ~32'(BUS - 1)) : 0;
      strd = MEM ? longint'(stride & ~32'(BUS - 1)) : 0;
      rows = int'(y) + 1;
      rbeats = int'(x) / BUS + 1;
      r = 0;
      o = 0;
    end
    e_done = d;
    calc();
  end
endmodule

module sim_dma2d_addr_gen;
  logic clk = 0;
  logic rst_n = 0;
  logic en = 0, load = 0, cyc = 0, rdy = 1;
  logic [31:0] addr = 0, stride = 0;
  logic [23:0] x = 0;
  logic [15:0] y = 0;
  bit rnd_rdy = 0;
  bit ended = 0;

  logic v0, rl0, xl0, d0, v1, rl1, xl1, d1;
  logic [31:0] a0, a1;
  logic [4:0] b0, b1;
  logic ev0, erl0, exl0, ed0, ev1, erl1, exl1, ed1;
  logic [31:0] ea0, ea1;
  int eb0, eb1;

  int n_chk = 0, n_fail = 0;
  int n_req = 0, n_rows = 0, n_beats = 0, n_done = 0, hits_base = 0, hits_bad = 0;
  logic [31:0] q[$];

  always #4 clk = ~clk;

  dma2d_addr_gen #(.MEM_SIDE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .cfg_load(load), .cfg_addr(addr),
    .cfg_xlen_m1(x), .cfg_ylen_m1(y), .cfg_stride(stride), .cfg_cyclic(cyc),
    .req_valid(v0), .req_ready(rdy), .req_addr(a0), .req_beats(b0),
    .req_row_last(rl0), .req_xfer_last(xl0), .done(d0));

  dma2d_addr_gen #(.MEM_SIDE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .enable(en), .cfg_load(load), .cfg_addr(addr),
    .cfg_xlen_m1(x), .cfg_ylen_m1(y), .cfg_stride(stride), .cfg_cyclic(cyc),
    .req_valid(v1), .req_ready(rdy), .req_addr(a1), .req_beats(b1),
    .req_row_last(rl1), .req_xfer_last(xl1), .done(d1));

  sim_ref #(.MEM(1'b1)) r0 (.clk(clk), .rst_n(rst_n), .en(en), .load(load), .addr(addr),
    .x(x), .y(y), .stride(stride), .cyc(cyc), .rdy(rdy), .e_valid(ev0), .e_addr(ea0),
    .e_beats(eb0), .e_row_last(erl0), .e_xfer_last(exl0), .e_done(ed0));

  sim_ref #(.MEM(1'b0)) r1 (.clk(clk), .rst_n(rst_n), .en(en), .load(load), .addr(addr),
    .x(x), .y(y), .stride(stride), .cyc(cyc), .rdy(rdy), .e_valid(ev1), .e_addr(ea1),
    .e_beats(eb1), .e_row_last(erl1), .e_xfer_last(exl1), .e_done(ed1));

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // stall pattern for back-pressure
  always @(negedge clk) rdy = rnd_rdy ? (($urandom % 3) != 0) : 1'b1;

  // per-cycle comparison against the reference, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    if (rst_n && !ended) begin
      check(v0 == ev0, "R10", "mem valid", v0, ev0);
      check(d0 == ed0, "R7", "mem done", d0, ed0);
      if (ev0) begin
        check(a0 == ea0, "R2", "mem addr", a0, ea0);
        check(int'(b0) == eb0, "R5", "mem beats", b0, eb0);
        check(rl0 == erl0, "R6", "mem row_last", rl0, erl0);
        check(xl0 == exl0, "R6", "mem xfer_last", xl0, exl0);
      end
      check(v1 == ev1, "R10", "stream valid", v1, ev1);
      check(d1 == ed1, "R7", "stream done", d1, ed1);
      if (ev1) begin
        check(a1 == ea1, "R12", "stream addr", a1, ea1);
        check(int'(b1) == eb1, "R12", "stream beats", b1, eb1);
        check(rl1 == erl1, "R6", "stream row_last", rl1, erl1);
        check(xl1 == exl1, "R6", "stream xfer_last", xl1, exl1);
      end
      if (v0 && rdy) begin
        n_req++;
        n_beats += int'(b0);
        q.push_back(a0);
        if (rl0) n_rows++;
        if (a0 == 32'h3000) hits_base++;
        if (a0 == 32'h7000) hits_bad++;
      end
      if (d0) n_done++;
    end
  end

  task automatic clr();
    n_req = 0; n_rows = 0; n_beats = 0; n_done = 0; hits_base = 0; hits_bad = 0;
    q.delete();
  endtask

  task automatic go(input logic [31:0] a, input int xl, input int yl,
                    input logic [31:0] s, input bit c);
    @(negedge clk);
    addr = a; x = 24'(xl); y = 16'(yl); stride = s; cyc = c; load = 1;
    @(negedge clk);
    load = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (r0.act || r1.act) @(negedge clk);
    repeat (2) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(v0 == 0 && v1 == 0, "R13", "valid in reset", {v0, v1}, 0);
    check(d0 == 0 && d1 == 0, "R13", "done in reset", {d0, d1}, 0);
    rst_n = 1;
    en = 1;

    // single long row, pitch must not matter
    clr(); go(32'h1000, 319, 0, 32'hDEAD0, 0); wait_idle();
    check(n_rows == 1, "R3", "row count", n_rows, 1);
    check(n_beats == 40, "R1", "beats", n_beats, 40);
    check(n_req == 3, "R5", "bursts", n_req, 3);

    // row straddling a boundary
    clr(); go(32'h0FC0, 159, 0, 0, 0); wait_idle();
    check(n_req == 2, "R5", "bursts at boundary", n_req, 2);
    check(q.size() > 1 && q[1] == 32'h1000, "R5", "second burst addr", q.size() > 1 ? q[1] : 0, 32'h1000);

    // three rows with a pitch, random stalls
    rnd_rdy = 1;
    clr(); go(32'h2000, 191, 2, 32'h400, 0); wait_idle();
    rnd_rdy = 0;
    check(n_rows == 3, "R1", "rows", n_rows, 3);
    check(n_beats == 72, "R1", "beats", n_beats, 72);
    check(q.size() > 4 && q[2] == 32'h2400, "R2", "row1 start", q.size() > 4 ? q[2] : 0, 32'h2400);
    check(q.size() > 4 && q[4] == 32'h2800, "R2", "row2 start", q.size() > 4 ? q[4] : 0, 32'h2800);
    check(n_done == 1, "R7", "done pulses", n_done, 1);

    // unaligned inputs
    clr(); go(32'h2005, 13, 1, 32'h103, 0); wait_idle();
    check(q.size() > 1 && q[0] == 32'h2000, "R4", "row0 addr", q.size() > 1 ? q[0] : 0, 32'h2000);
    check(q.size() > 1 && q[1] == 32'h2100, "R4", "row1 addr", q.size() > 1 ? q[1] : 0, 32'h2100);
    check(n_beats == 4, "R4", "beats", n_beats, 4);

    // repeat mode, a load while busy, then a stop
    clr(); go(32'h3000, 63, 1, 32'h200, 1);
    repeat (6) @(negedge clk);
    go(32'h7000, 63, 0, 0, 0);
    repeat (6) @(negedge clk);
    en = 0;
    repeat (4) @(negedge clk);
    #2;
    check(v0 == 0 && v1 == 0, "R9", "stopped", {v0, v1}, 0);
    check(n_done >= 3, "R8", "passes done", n_done, 3);
    check(hits_base >= 3, "R8", "restarts at base", hits_base, 3);
    check(hits_bad == 0, "R11", "busy load ignored", hits_bad, 0);
    en = 1;
    repeat (4) @(negedge clk);
    #2;
    check(v0 == 0 && v1 == 0, "R9", "no resume", {v0, v1}, 0);

    // load while disabled
    en = 0;
    go(32'h4000, 63, 0, 0, 0);
    repeat (4) @(negedge clk);
    #2;
    check(v0 == 0 && v1 == 0, "R11", "disabled load", {v0, v1}, 0);
    en = 1;
    repeat (3) @(negedge clk);
    #2;
    check(v0 == 0 && v1 == 0, "R11", "no late start", {v0, v1}, 0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule